// File: doc/BRIEF.md
# USB Host Root Port Reset Controller

This block holds the status and control word of one USB host root port and runs the bus reset on that port. Host software reaches it through a simple register interface with a write strobe and a combinational read path. A line-state detector supplies two inputs: whether a device is attached, and the speed code that device settled on.

Software starts a reset by writing 1 to the reset bit. From then on the block times the reset itself for `RESET_CYCLES` clocks and ignores any write that tries to end or restart it. When the timer runs out and a device is still attached, the port becomes enabled. The negotiated speed is captured into a 2-bit field and into a separate high-speed flag. An enable-change status bit is set, and it drives the interrupt output when the interrupt enable is set. The port-owner bit always reads 0, so devices of every speed stay on this controller.

Register map. Address 0 is the port word: bit 0 connected (read-only), bit 1 enabled (read-only), bit 2 enable-change (write 1 to clear), bit 3 reset, bit 4 owner (read-only, 0), bits 6:5 speed, bit 7 high-speed flag. Address 1, bit 0, is the interrupt enable. Reads of every other bit and address return 0.

Top module: `usb_port_reset_ctrl`

## Requirements
- R1: Writing 1 to bit 3 at address 0 while no reset runs starts a reset. From the next cycle, bit 3 reads 1 and bit 1 (enabled) reads 0.
- R2: While a reset runs, writing 0 or 1 to bit 3 neither ends it nor restarts its timer.
- R3: A reset ends by itself exactly `RESET_CYCLES` cycles after the write that started it. Bit 3 then reads 0.
- R4: When a reset ends with a device connected, bit 1 (enabled) and bit 2 (enable-change) both become 1.
- R5: Bits 6:5 capture the detector speed at the end of the reset: 00 full, 01 low, 10 high. A detector code of 11 is recorded as 00. The field holds while the detector input changes afterwards.
- R6: Bit 7 reads 1 exactly when bits 6:5 read 10.
- R7: Bit 4 (owner) always reads 0, and writes to it have no effect.
- R8: Writing 1 to bit 2 clears it. Writing 0 to bit 2 leaves it unchanged.
- R9: `port_irq` is high exactly when bit 2 at address 0 and bit 0 at address 1 are both 1.
- R10: Bit 0 follows `dev_connected`. One edge after a disconnect, enabled, speed and the high-speed flag read 0. A reset that ends with no device attached leaves the port disabled with bit 2 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| dev_connected | input | 1 | Detector: device attached |
| dev_speed | input | 2 | Detector: speed code of the attached device |
| port_irq | output | 1 | Port-change interrupt |

## Verification
The bench builds the block with `RESET_CYCLES` = 40 instead of the ten-millisecond default. This makes the last cycle of a reset and the completion edge short enough to check many times within one run. At that length, writes to the reset bit can be placed in the middle of a running reset, and about twenty randomized resets can sweep every detector code, including the reserved one, across both interrupt-enable settings.

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;
  typedef enum logic [1:0] {
    SPD_FULL = 2'b00,
    SPD_LOW  = 2'b01,
    SPD_HIGH = 2'b10,
    SPD_RSVD = 2'b11
  } port_speed_e;

  localparam int BIT_CONNECTED = 0;
  localparam int BIT_ENABLED   = 1;
  localparam int BIT_EN_CHG    = 2;
  localparam int BIT_RESET     = 3;
  localparam int BIT_OWNER     = 4;
  localparam int BIT_SPEED_LSB = 5;
  localparam int BIT_HISPEED   = 7;
  localparam int BIT_IRQ_EN    = 0;
endpackage

// File: rtl/usb_port_rst_timer.sv
module usb_port_rst_timer #(
  parameter int RESET_CYCLES = 480000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int CNT_W = (RESET_CYCLES > 1) ? $clog2(RESET_CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RESET_CYCLES - 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, launch;

  assign launch = start && !active_q;
  assign done   = active_q && (cnt_q == '0);

  always_comb begin
    cnt_en   = launch || (active_q && (cnt_q != '0));
    cnt_d    = launch ? LOAD_VAL : (cnt_q - 1'b1);
    active_d = active_q;
    if (launch)    active_d = 1'b1;
    else if (done) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else begin
      active_q <= active_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active = active_q;

  // R2: a running reset is neither ended early nor reloaded by new starts
  assert_reset_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && (cnt_q != '0)) |=> (active_q && (cnt_q == $past(cnt_q) - 1'b1)));

  // R3: completion always drops the active state
  assert_reset_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !active_q);
endmodule

// File: rtl/usb_port_status.sv
module usb_port_status
  import usb_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       connected,
  input  logic [1:0] det_speed,
  input  logic       rst_start,
  input  logic       rst_done,
  input  logic       chg_clr,
  output logic       enabled,
  output logic       en_chg,
  output logic [1:0] speed,
  output logic       hispeed
);
  logic       en_q, en_d;
  logic       chg_q, chg_d, chg_upd;
  logic [1:0] spd_q, spd_d;
  logic       hs_q, hs_d, spd_upd;
  logic       attach_done;

  assign attach_done = rst_done && connected;

  always_comb begin
    en_d = en_q;
    if (!connected)       en_d = 1'b0;
    else if (rst_start)   en_d = 1'b0;
    else if (attach_done) en_d = 1'b1;
  end

  always_comb begin
    chg_upd = attach_done || chg_clr;
    chg_d   = attach_done;
  end

  always_comb begin
    spd_upd = !connected || rst_start || attach_done;
    spd_d   = SPD_FULL;
    hs_d    = 1'b0;
    if (attach_done && connected) begin
      spd_d = (det_speed == SPD_RSVD) ? SPD_FULL : det_speed;
      hs_d  = (det_speed == SPD_HIGH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= 1'b0;
    end else if (chg_upd) begin
      chg_q <= chg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q <= SPD_FULL;
      hs_q  <= 1'b0;
    end else if (spd_upd) begin
      spd_q <= spd_d;
      hs_q  <= hs_d;
    end
  end

  assign enabled = en_q;
  assign en_chg  = chg_q;
  assign speed   = spd_q;
  assign hispeed = hs_q;

  // R4: completion with a device enables the port and flags the change
  assert_done_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    attach_done |=> (en_q && chg_q));

  // R6: flag and speed field agree
  assert_hs_agrees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_q == (spd_q == SPD_HIGH));

  // R5: reserved code is never recorded
  assert_no_rsvd_speed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spd_q != SPD_RSVD);

  // R10: disconnect clears the enabled state
  assert_disconnect_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !connected |=> (!en_q && (spd_q == SPD_FULL)));
endmodule

// File: rtl/usb_port_reset_ctrl.sv
module usb_port_reset_ctrl
  import usb_port_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 32,
  parameter int RESET_CYCLES = 480000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dev_connected,
  input  logic [1:0]        dev_speed,
  output logic              port_irq
);
  localparam logic [ADDR_W-1:0] ADDR_PORT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_IRQEN = ADDR_W'(1);

  logic       port_wr, irqen_wr;
  logic       rst_start, rst_active, rst_done, chg_clr;
  logic       enabled, en_chg, hispeed;
  logic [1:0] speed;
  logic       ie_q, ie_d;

  assign port_wr   = wr_en && (wr_addr == ADDR_PORT);
  assign irqen_wr  = wr_en && (wr_addr == ADDR_IRQEN);
  assign rst_start = port_wr && wr_data[BIT_RESET] && !rst_active;
  assign chg_clr   = port_wr && wr_data[BIT_EN_CHG];
  assign ie_d      = wr_data[BIT_IRQ_EN];

  usb_port_rst_timer #(.RESET_CYCLES(RESET_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rst_start),
    .active (rst_active),
    .done   (rst_done)
  );

  usb_port_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .connected (dev_connected),
    .det_speed (dev_speed),
    .rst_start (rst_start),
    .rst_done  (rst_done),
    .chg_clr   (chg_clr),
    .enabled   (enabled),
    .en_chg    (en_chg),
    .speed     (speed),
    .hispeed   (hispeed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
    end else if (irqen_wr) begin
      ie_q <= ie_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_PORT) begin
      rd_data[BIT_CONNECTED]                 = dev_connected;
      rd_data[BIT_ENABLED]                   = enabled;
      rd_data[BIT_EN_CHG]                    = en_chg;
      rd_data[BIT_RESET]                     = rst_active;
      rd_data[BIT_OWNER]                     = 1'b0;
      rd_data[BIT_SPEED_LSB+1:BIT_SPEED_LSB] = speed;
      rd_data[BIT_HISPEED]                   = hispeed;
    end else if (rd_addr == ADDR_IRQEN) begin
      rd_data[BIT_IRQ_EN] = ie_q;
    end
  end

  assign port_irq = en_chg && ie_q;

  // R1: an accepted start shows the reset running and the port disabled
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start |=> (rst_active && !enabled));

  // R9: clearing the change bit with no completion drops the interrupt
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_clr && !rst_done) |=> !port_irq);
endmodule

// File: tb/usb_port_reset_ctrl_test.sv
module usb_port_reset_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int RST_LEN    = 40;
  localparam int ADDR_W     = 2;
  localparam int DATA_W     = 32;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              dev_connected;
  logic [1:0]        dev_speed;
  logic              port_irq;

  int checks = 0;
  int errors = 0;

  usb_port_reset_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_CYCLES(RST_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dev_connected(dev_connected),
    .dev_speed(dev_speed), .port_irq(port_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_port(bit conn, bit en, bit chg, bit pr, logic [1:0] spd);
    logic [31:0] w;
    w      = '0;
    w[0]   = conn;
    w[1]   = en;
    w[2]   = chg;
    w[3]   = pr;
    w[6:5] = spd;
    w[7]   = (spd == 2'b10);
    return w;
  endfunction

  function automatic logic [1:0] exp_speed(logic [1:0] det);
    return (det == 2'b11) ? 2'b00 : det;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd_port(output logic [31:0] v);
    rd_addr = 2'd0;
    #1 v = rd_data;
  endtask

  // called at a negedge; consumes exactly one posedge, returns at the next negedge
  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [1:0]  s;
    bit          ie;
    void'($urandom(32'd5150));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    dev_connected = 1'b0; dev_speed = 2'b00;
    step(3);
    rst_n = 1'b1;
    step(1);

    rd_port(v); check("R10 reset state", v, exp_port(0, 0, 0, 0, 2'b00));
    check("R9 reset irq", {31'b0, port_irq}, 32'd0);

    dev_connected = 1'b1; dev_speed = 2'b10;
    rd_port(v); check("R10 connect bit", v, exp_port(1, 0, 0, 0, 2'b00));

    wr(2'd1, 32'h1);
    wr(2'd0, 32'h8);                 // start edge E0
    rd_port(v); check("R1 reset running", v, exp_port(1, 0, 0, 1, 2'b00));
    wr(2'd0, 32'h0);                 // E0+1: attempt to end
    rd_port(v); check("R2 clear ignored", v, exp_port(1, 0, 0, 1, 2'b00));
    wr(2'd0, 32'h8);                 // E0+2: attempt to restart
    step(RST_LEN - 3);               // after E0+RST_LEN-1
    rd_port(v); check("R2 last reset cycle", v, exp_port(1, 0, 0, 1, 2'b00));
    step(1);                         // after E0+RST_LEN
    rd_port(v); check("R3 R4 R6 completion", v, exp_port(1, 1, 1, 0, 2'b10));
    check("R9 irq raised", {31'b0, port_irq}, 32'd1);

    dev_speed = 2'b01;
    step(2);
    rd_port(v); check("R5 speed holds", v, exp_port(1, 1, 1, 0, 2'b10));

    wr(2'd0, 32'h0);
    rd_port(v); check("R8 write 0 keeps change", v, exp_port(1, 1, 1, 0, 2'b10));
    wr(2'd0, 32'h10);
    rd_port(v); check("R7 owner reads 0", v, exp_port(1, 1, 1, 0, 2'b10));
    wr(2'd0, 32'h4);
    rd_port(v); check("R8 w1c change", v, exp_port(1, 1, 0, 0, 2'b10));
    check("R9 irq cleared", {31'b0, port_irq}, 32'd0);

    dev_connected = 1'b0;
    rd_port(v); check("R10 connect follows", {31'b0, v[0]}, 32'd0);
    step(1);
    rd_port(v); check("R10 disconnect clears", v, exp_port(0, 0, 0, 0, 2'b00));

    wr(2'd0, 32'h8);
    step(RST_LEN);
    rd_port(v); check("R10 reset without device", v, exp_port(0, 0, 0, 0, 2'b00));

    dev_connected = 1'b1;
    for (int i = 0; i < 20; i++) begin
      s  = 2'($urandom % 4);
      ie = bit'($urandom % 2);
      if (i == 0) s = 2'b11;
      wr(2'd1, {31'b0, ie});
      dev_speed = 2'($urandom % 4);
      wr(2'd0, 32'h8);
      dev_speed = s;
      step(RST_LEN - 1);
      rd_port(v); check("R1 R3 random reset running", v, exp_port(1, 0, 0, 1, 2'b00));
      step(1);
      dev_speed = 2'($urandom % 4);
      rd_port(v); check("R5 R6 random speed", v, exp_port(1, 1, 1, 0, exp_speed(s)));
      check("R9 random irq", {31'b0, port_irq}, {31'b0, ie});
      wr(2'd0, 32'h4);
      check("R9 random irq cleared", {31'b0, port_irq}, 32'd0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule